// File: doc/BRIEF.md
# Iterative Booth Carry-Save Multiply-Accumulate Unit

The block computes the low 32 bits of `A*B + C` over several clock cycles. A start pulse captures the multiplicand, the multiplier and, when accumulation is enabled, an addend. Each iteration recodes eight multiplier bits into four radix-4 Booth digits. Each digit drives one layer of a four-layer carry-save adder stack. The partial sum and partial carry stay in redundant form in registers between cycles, so no carry chain is resolved while the loop runs.

The multiplier register shifts right arithmetically by eight bits per iteration. Its top consumed bit is kept as the overlap bit for the next iteration's lowest Booth group. The loop ends as soon as the bits still to come would recode only to zero digits, or after four iterations. One carry-propagate add then merges sum and carry into the result, and `done_o` pulses. Because the result is taken modulo 2^32, it is the same whether the operands are read as signed or unsigned.

Top module: `booth_mac`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0.
- R2: When `start_i` is high while the unit is idle, the operands are captured. The result delivered with the next `done_o` pulse is `(mcand_i*mplier_i + (acc_en_i ? acc_i : 0)) mod 2^32`.
- R3: When `acc_en_i` is 0 at start, `acc_i` has no effect on the result, which equals `mcand_i*mplier_i mod 2^32`.
- R4: Operands in two's complement give the signed product modulo 2^32. For example, 0xFFFFFFFC (−4) times 7 gives 0xFFFFFFE4 (−28).
- R5: `done_o` rises exactly k+1 clock edges after the start edge. For k = 0..3, k is the smallest value for which the multiplier arithmetically shifted right by 8k is all zeros with overlap bit 0, or all ones with overlap bit 1. The overlap bit is bit 8k−1 of the multiplier, or 0 when k = 0. If no k up to 3 qualifies, k = 4.
- R6: `done_o` is high for exactly one cycle, and `result_o` holds its value until the next `done_o` pulse.
- R7: A `start_i` pulse while an operation is in progress is ignored. The running result and its latency are unchanged, and no extra `done_o` pulse follows.
- R8: A zero multiplier skips all iterations. `done_o` follows one edge after start, and the result equals the addend (or 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier, Booth-recoded |
| acc_i | input | 32 | Addend |
| acc_en_i | input | 1 | Use `acc_i` as the initial partial sum |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |
| result_o | output | 32 | Low 32 bits of the multiply-accumulate |

## Verification
Directed multipliers each select one Booth path or stop point:
- small positive values stop after one slice;
- −1 exercises the all-ones stop with overlap 1;
- 0x80000000 and 0x00FF0000 force all four iterations;
- zero checks the skip.

These show whether digit recoding, the overlap bit and early termination are right, independently of each other. Single-bit multipliers at every position show whether each layer applies its 2k shift and each cycle its 8-bit step. Random operands, with and without accumulation, exercise negative digits and carry injection broadly. Start pulses sent mid-operation tell a correctly ignored request apart from a restart, which would change either the latency or the result.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} mac_state_e;

  // one radix-4 digit: magnitude one, magnitude two, negate
  typedef struct packed {
    logic neg;
    logic dbl;
    logic sel;
  } booth_dig_t;

  function automatic booth_dig_t booth_recode(input logic [2:0] grp);
    booth_dig_t d;
    d = '0;
    unique case (grp)
      3'b001, 3'b010: d.sel = 1'b1;
      3'b011:         d.dbl = 1'b1;
      3'b100:         begin d.dbl = 1'b1; d.neg = 1'b1; end
      3'b101, 3'b110: begin d.sel = 1'b1; d.neg = 1'b1; end
      default:        d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/booth_pp_row.sv
module booth_pp_row
  import booth_mac_pkg::*;
#(
  parameter int W  = 32,
  parameter int SH = 0
) (
  input  logic [W-1:0] mcand_i,
  input  logic [2:0]   grp_i,
  output logic [W-1:0] row_o,
  output logic         neg_o
);
  booth_dig_t   dig;
  logic [W-1:0] mag1, mag2, mag;

  assign dig  = booth_recode(grp_i);
  assign mag1 = mcand_i << SH;
  assign mag2 = mcand_i << (SH + 1);

  always_comb begin
    if (dig.dbl)      mag = mag2;
    else if (dig.sel) mag = mag1;
    else              mag = '0;
  end

  // negative rows: ones' complement here, +1 injected into the carry lsb
  assign row_o = dig.neg ? ~mag : mag;
  assign neg_o = dig.neg;
endmodule

// File: rtl/csa_layer.sv
module csa_layer #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] maj;

  assign sum_o   = a_i ^ b_i ^ c_i;
  assign maj     = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  // msb carry leaves the modulo-2^W window
  assign carry_o = {maj[W-2:0], cin_i};
endmodule

// File: rtl/booth_csa_stack.sv
module booth_csa_stack #(
  parameter int W      = 32,
  parameter int DIGITS = 4
) (
  input  logic [W-1:0]        mcand_i,
  input  logic [2*DIGITS-1:0] slice_i,
  input  logic                ov_i,
  input  logic [W-1:0]        sum_i,
  input  logic [W-1:0]        carry_i,
  output logic [W-1:0]        sum_o,
  output logic [W-1:0]        carry_o
);
  localparam int EW = 2 * DIGITS + 1;

  logic [EW-1:0] ext;
  logic [W-1:0]  s_w [DIGITS+1];
  logic [W-1:0]  c_w [DIGITS+1];

  assign ext    = {slice_i, ov_i};
  assign s_w[0] = sum_i;
  assign c_w[0] = carry_i;

  for (genvar k = 0; k < DIGITS; k++) begin : g_layer
    logic [W-1:0] row;
    logic         neg;

    booth_pp_row #(.W(W), .SH(2 * k)) i_row (
      .mcand_i (mcand_i),
      .grp_i   (ext[2*k+2:2*k]),
      .row_o   (row),
      .neg_o   (neg)
    );

    csa_layer #(.W(W)) i_csa (
      .a_i     (s_w[k]),
      .b_i     (c_w[k]),
      .c_i     (row),
      .cin_i   (neg),
      .sum_o   (s_w[k+1]),
      .carry_o (c_w[k+1])
    );
  end

  assign sum_o   = s_w[DIGITS];
  assign carry_o = c_w[DIGITS];
endmodule

// File: rtl/booth_mac_ctrl.sv
module booth_mac_ctrl
  import booth_mac_pkg::*;
#(
  parameter int MAX_ITER = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic skip_i,
  input  logic stop_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic idle_o
);
  localparam int CW = $clog2(MAX_ITER + 1);

  mac_state_e    st_q, st_d;
  logic [CW-1:0] iter_q;
  logic          last_iter;

  assign last_iter = (iter_q == CW'(MAX_ITER - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = skip_i ? ST_FIN : ST_RUN;
      ST_RUN:  if (stop_i || last_iter) st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign load_o = (st_q == ST_IDLE) && start_i;
  assign step_o = (st_q == ST_RUN);
  assign fin_o  = (st_q == ST_FIN);
  assign idle_o = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      iter_q <= '0;
    end else begin
      st_q <= st_d;
      if (load_o)      iter_q <= '0;
      else if (step_o) iter_q <= iter_q + 1'b1;
    end
  end
endmodule

// File: rtl/booth_mac.sv
module booth_mac
  import booth_mac_pkg::*;
#(
  parameter int W      = 32,
  parameter int DIGITS = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  input  logic [W-1:0] acc_i,
  input  logic         acc_en_i,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  localparam int BPC      = 2 * DIGITS;
  localparam int MAX_ITER = W / BPC;

  logic [W-1:0] mcand_q, mreg_q, sum_q, carry_q;
  logic         ov_q;
  logic [W-1:0] next_m, sum_w, carry_w;
  logic         next_ov;
  logic         load, step, fin, idle_w;
  logic         skip, stop;

  // remaining bits recode to all-zero digits
  function automatic logic neutral(input logic [W-1:0] m, input logic ov);
    return ((m == '0) && !ov) || ((&m) && ov);
  endfunction

  assign next_m  = W'($signed(mreg_q) >>> BPC);
  assign next_ov = mreg_q[BPC-1];
  assign skip    = neutral(mplier_i, 1'b0);
  assign stop    = neutral(next_m, next_ov);

  booth_mac_ctrl #(.MAX_ITER(MAX_ITER)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .skip_i  (skip),
    .stop_i  (stop),
    .load_o  (load),
    .step_o  (step),
    .fin_o   (fin),
    .idle_o  (idle_w)
  );

  booth_csa_stack #(.W(W), .DIGITS(DIGITS)) i_stack (
    .mcand_i (mcand_q),
    .slice_i (mreg_q[BPC-1:0]),
    .ov_i    (ov_q),
    .sum_i   (sum_q),
    .carry_i (carry_q),
    .sum_o   (sum_w),
    .carry_o (carry_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mreg_q   <= '0;
      ov_q     <= 1'b0;
      sum_q    <= '0;
      carry_q  <= '0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= fin;
      if (load) begin
        mcand_q <= mcand_i;
        mreg_q  <= mplier_i;
        ov_q    <= 1'b0;
        sum_q   <= acc_en_i ? acc_i : '0;
        carry_q <= '0;
      end else if (step) begin
        // multiplicand moves up one slice; redundant words stay aligned
        mcand_q <= mcand_q << BPC;
        mreg_q  <= next_m;
        ov_q    <= next_ov;
        sum_q   <= sum_w;
        carry_q <= carry_w;
      end
      if (fin) result_o <= sum_q + carry_q;
    end
  end
endmodule

// File: rtl/booth_mac_chk.sv
module booth_mac_chk #(
  parameter int W        = 32,
  parameter int MAX_ITER = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] mcand_i,
  input logic [W-1:0] mplier_i,
  input logic [W-1:0] acc_i,
  input logic         acc_en_i,
  input logic         done_o,
  input logic [W-1:0] result_o,
  input logic         idle_i
);
  logic [W-1:0] exp_q;
  int unsigned  busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q    <= '0;
      busy_cnt <= 0;
    end else begin
      if (idle_i && start_i) exp_q <= mcand_i * mplier_i + (acc_en_i ? acc_i : '0);
      busy_cnt <= idle_i ? 0 : busy_cnt + 1;
    end
  end

  assert_result_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> result_o == exp_q);

  assert_latency_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= MAX_ITER + 1);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  assert_zero_skip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && start_i && mplier_i == '0) |=> ##1 done_o);
endmodule

bind booth_mac booth_mac_chk #(.W(W), .MAX_ITER(MAX_ITER)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .mcand_i  (mcand_i),
  .mplier_i (mplier_i),
  .acc_i    (acc_i),
  .acc_en_i (acc_en_i),
  .done_o   (done_o),
  .result_o (result_o),
  .idle_i   (idle_w)
);

// File: tb/test_booth_mac.sv
module test_booth_mac;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         acc_en = 1'b0;
  logic [W-1:0] a = '0, b = '0, c = '0;
  logic         done;
  logic [W-1:0] res;

  int checks = 0, errors = 0, cyc = 0, outstanding = 0;
  bit finished = 1'b0;

  logic [W-1:0] exp_q[$];
  int           lat_q[$];
  int           t0_q[$];
  string        req_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  booth_mac i_booth_mac (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mcand_i(a), .mplier_i(b),
    .acc_i(c), .acc_en_i(acc_en), .done_o(done), .result_o(res)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic int exp_lat(input logic [W-1:0] m);
    if (m == '0) return 0;
    for (int j = 1; j < 4; j++) begin
      logic [W-1:0] rem;
      logic         ovb;
      rem = W'($signed(m) >>> (8 * j));
      ovb = m[8*j-1];
      if ((rem == '0 && !ovb) || (&rem && ovb)) return j;
    end
    return 4;
  endfunction

  // driver: one operation, optional start poke while busy
  task automatic run_op(input logic [W-1:0] ma, input logic [W-1:0] mb,
                        input logic [W-1:0] mc, input logic en,
                        input string req, input bit poke);
    logic [W-1:0] e;
    e = ma * mb + (en ? mc : '0);
    @(negedge clk);
    a = ma; b = mb; c = mc; acc_en = en; start = 1'b1;
    exp_q.push_back(e);
    lat_q.push_back(exp_lat(mb));
    t0_q.push_back(cyc + 1);
    req_q.push_back(req);
    outstanding++;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      a = $urandom; b = $urandom; c = $urandom; acc_en = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (outstanding != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check({req, " R6 hold"}, res, e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected done: actual result %h expected none", res);
      end else begin
        logic [W-1:0] e;
        int l, t;
        string r;
        e = exp_q.pop_front(); l = lat_q.pop_front();
        t = t0_q.pop_front();  r = req_q.pop_front();
        check(r, res, e);
        checks++;
        if (cyc - t != l + 1) begin
          errors++;
          $display("FAIL R5 latency (%s): actual %0d expected %0d", r, cyc - t, l + 1);
        end
        outstanding--;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 done after reset", {31'b0, done}, '0);
    check("R1 result after reset", res, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(32'hFFFF_FFFC, 32'd7, 32'h0, 1'b0, "R4 -4*7", 1'b0);
    run_op(32'd29, 32'd43, 32'h0, 1'b0, "R2 29*43", 1'b0);
    run_op(32'h1234_5678, 32'hFFFF_FFFF, 32'h0, 1'b0, "R4 times -1", 1'b0);
    run_op(32'h0BAD_F00D, 32'h8000_0000, 32'd5, 1'b1, "R5 top bit", 1'b0);
    run_op(32'h7777_1111, 32'h00FF_0000, 32'd9, 1'b1, "R5 mid ones", 1'b0);
    run_op(32'hDEAD_BEEF, 32'h0, 32'hCAFE_0001, 1'b1, "R8 zero acc", 1'b0);
    run_op(32'hDEAD_BEEF, 32'h0, 32'hCAFE_0001, 1'b0, "R8 zero noacc", 1'b0);
    run_op(32'h0001_0003, 32'h0000_0105, 32'hFFFF_FFFF, 1'b0, "R3 acc ignored", 1'b0);
    run_op(32'h0001_0003, 32'h0000_0105, 32'hFFFF_FFFF, 1'b1, "R2 acc used", 1'b0);

    for (int n = 0; n < W; n++)
      run_op($urandom, 32'h1 << n, $urandom, n[0], "R2 sparse", 1'b0);
    for (int i = 0; i < 40; i++)
      run_op($urandom, $urandom, $urandom, i[0], "R2 random", 1'b0);
    for (int i = 0; i < 4; i++)
      run_op($urandom, (i == 0) ? 32'h0 : $urandom, $urandom, 1'b1, "R7 poke", 1'b1);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R5 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule